// File: doc/BRIEF.md
# Rewindable FIFO with Half-Level Flag

This block is a single-clock first-in first-out buffer. It holds data words (9 bits by default) in a memory whose depth is a power of two set by a parameter. Writes and reads are requested with active-low strobes that the block samples on the rising clock edge. Active-low flags report when the buffer is empty, full, or holding more than half its capacity. A registered read port returns each word together with a valid qualifier. The qualifier takes the place of a bus that would otherwise float between reads.

The block protects itself against misuse. A write into a full buffer is dropped. A read from an empty buffer does nothing.

An active-low rewind input moves the read side back to memory location zero. The buffer can then deliver everything written since reset again, for example when a receiver rejects a packet and asks for it once more. The rewind is exact when no more words than the depth have been written since reset. After a rewind, the occupancy and all three flags are recomputed from the pointer positions.

Top module: `fifo_rt`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `empty_n` is 0, `full_n` is 1, `half_n` is 1 and `rd_valid` is 0.
- R2: Words are returned in the order they were accepted. The word for a read accepted at a clock edge is on `rd_data` with `rd_valid` = 1 after that edge, and `rd_valid` is 0 after any edge with no accepted read.
- R3: `empty_n` is 1 after an edge that leaves at least one word stored. It is 0 after an edge that leaves none.
- R4: A write strobe while the buffer holds DEPTH words is discarded. Nothing is stored and the write side does not advance.
- R5: A read strobe while the buffer is empty is ignored. `rd_valid` stays 0 and the read side does not advance.
- R6: `half_n` is 0 when the occupancy is DEPTH/2+1 or more. It is 1 when the occupancy is DEPTH/2 or less.
- R7: `full_n` is 0 exactly when the occupancy equals DEPTH. It returns to 1 after the next accepted read.
- R8: An edge with `rt_n` = 0 sets the read side to location zero and the occupancy to the number of writes since reset. Read and write strobes at that edge are ignored.
- R9: After a rewind, reads deliver every word from the first one written onward, including words already read, followed by words written after the rewind.
- R10: A read and a write accepted at the same edge, with the buffer neither empty nor full, leave the occupancy unchanged and both complete.
- R11: A read and a write at the same edge on an empty buffer store the word, and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| wr_n | input | 1 | Active-low write strobe |
| wr_data | input | WIDTH | Word to store |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low rewind request |
| rd_data | output | WIDTH | Word returned by the last accepted read |
| rd_valid | output | 1 | High for one cycle after each accepted read |
| empty_n | output | 1 | Low while no word is stored |
| full_n | output | 1 | Low while DEPTH words are stored |
| half_n | output | 1 | Low while more than DEPTH/2 words are stored |

## Verification
The bench builds the block with WIDTH = 9 and ADDR_BITS = 3, a depth of eight words. With that depth, the full boundary, the half-level threshold between four and five words, and the pointer wrap-around all occur within a few dozen cycles. It also allows a rewind with exactly a full buffer's worth of writes since reset. That is the edge case where the write side has wrapped to location zero and the occupancy must still come back as eight rather than zero.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  typedef struct packed {
    logic empty_n;
    logic full_n;
    logic half_n;
  } fifo_flags_t;

  localparam fifo_flags_t FLAGS_RESET = '{empty_n: 1'b0, full_n: 1'b1, half_n: 1'b1};
endpackage

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
  parameter int WIDTH     = 9,
  parameter int ADDR_BITS = 9
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [ADDR_BITS-1:0] waddr,
  input  logic [WIDTH-1:0]     wdata,
  input  logic                 re,
  input  logic [ADDR_BITS-1:0] raddr,
  output logic [WIDTH-1:0]     rdata
);
  localparam int DEPTH = 2 ** ADDR_BITS;

  logic [WIDTH-1:0] store [DEPTH];

  // Plain dual-port array with a registered read, no reset: maps to block RAM.
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl #(
  parameter int ADDR_BITS = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_req,
  input  logic                 rd_req,
  input  logic                 rt_req,
  output logic                 wr_go,
  output logic                 rd_go,
  output logic [ADDR_BITS-1:0] wr_addr,
  output logic [ADDR_BITS-1:0] rd_addr,
  output logic [ADDR_BITS:0]   level_nxt
);
  localparam int DEPTH = 2 ** ADDR_BITS;
  localparam logic [ADDR_BITS:0] FULL_LVL = DEPTH[ADDR_BITS:0];

  logic [ADDR_BITS:0] wptr, rptr, level;

  // A rewind takes priority; strobes at the same edge are dropped.
  assign wr_go = wr_req && !rt_req && (level != FULL_LVL);
  assign rd_go = rd_req && !rt_req && (level != '0);

  assign wr_addr = wptr[ADDR_BITS-1:0];
  assign rd_addr = rptr[ADDR_BITS-1:0];

  always_comb begin
    if (rt_req)
      level_nxt = wptr;  // read side back at zero: occupancy = writes since reset
    else
      level_nxt = level + {{ADDR_BITS{1'b0}}, wr_go} - {{ADDR_BITS{1'b0}}, rd_go};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      level <= level_nxt;
      if (wr_go) wptr <= wptr + 1'b1;
      if (rt_req) rptr <= '0;
      else if (rd_go) rptr <= rptr + 1'b1;
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_LVL); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !rd_req && !rt_req && level == FULL_LVL) |=> $stable(wptr)); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !wr_req && !rt_req && level == '0) |=> $stable(rptr)); // R5
  AST_REWIND_ZERO: assert property (@(posedge clk) disable iff (rst)
    rt_req |=> (rptr == '0)); // R8
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_req && rd_req && !rt_req && level != '0 && level != FULL_LVL) |=> $stable(level)); // R10
endmodule

// File: rtl/fifo_rt_flags.sv
module fifo_rt_flags
  import fifo_rt_pkg::*;
#(
  parameter int ADDR_BITS = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_BITS:0] level_nxt,
  output fifo_flags_t        flags
);
  localparam int DEPTH = 2 ** ADDR_BITS;
  localparam logic [ADDR_BITS:0] FULL_LVL = DEPTH[ADDR_BITS:0];
  localparam logic [ADDR_BITS:0] HALF_LVL = FULL_LVL >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= FLAGS_RESET;
    end else begin
      flags.empty_n <= (level_nxt != '0);
      flags.full_n  <= (level_nxt != FULL_LVL);
      flags.half_n  <= (level_nxt <= HALF_LVL);
    end
  end

  AST_EMPTY_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
    !(!flags.empty_n && !flags.full_n)); // R3
  AST_FULL_IMPLIES_HALF: assert property (@(posedge clk) disable iff (rst)
    !flags.full_n |-> !flags.half_n); // R6
  AST_EMPTY_NOT_HALF: assert property (@(posedge clk) disable iff (rst)
    !flags.empty_n |-> flags.half_n); // R6
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt
  import fifo_rt_pkg::*;
#(
  parameter int WIDTH     = 9,
  parameter int ADDR_BITS = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_n,
  input  logic             rt_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n
);
  logic                 wr_go, rd_go;
  logic [ADDR_BITS-1:0] wr_addr, rd_addr;
  logic [ADDR_BITS:0]   level_nxt;
  fifo_flags_t          flags;

  fifo_rt_ctrl #(.ADDR_BITS(ADDR_BITS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_req    (!wr_n),
    .rd_req    (!rd_n),
    .rt_req    (!rt_n),
    .wr_go     (wr_go),
    .rd_go     (rd_go),
    .wr_addr   (wr_addr),
    .rd_addr   (rd_addr),
    .level_nxt (level_nxt)
  );

  fifo_rt_mem #(.WIDTH(WIDTH), .ADDR_BITS(ADDR_BITS)) u_mem (
    .clk   (clk),
    .we    (wr_go),
    .waddr (wr_addr),
    .wdata (wr_data),
    .re    (rd_go),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  fifo_rt_flags #(.ADDR_BITS(ADDR_BITS)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .level_nxt (level_nxt),
    .flags     (flags)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_go;
  end

  assign empty_n = flags.empty_n;
  assign full_n  = flags.full_n;
  assign half_n  = flags.half_n;

  AST_VALID_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!rd_n && rt_n)); // R2
  AST_EMPTY_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!empty_n && !rd_n) |=> !rd_valid); // R5
endmodule

// File: tb/test_fifo_rt.sv
`timescale 1ns/1ps
module test_fifo_rt;
  localparam int W     = 9;
  localparam int AW    = 3;
  localparam int DEPTH = 2 ** AW;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         rd_valid, empty_n, full_n, half_n;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string cur_tag = "R2";

  int hist[$];
  int expq[$];
  int widx = 0, ridx = 0;

  always #4 clk = ~clk;

  fifo_rt #(.WIDTH(W), .ADDR_BITS(AW)) i_fifo_rt (
    .clk(clk), .rst(rst), .wr_n(wr_n), .wr_data(wr_data), .rd_n(rd_n),
    .rt_n(rt_n), .rd_data(rd_data), .rd_valid(rd_valid),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lvl();
    return widx - ridx;
  endfunction

  task automatic check_flags(input string tag);
    chk(empty_n == (lvl() != 0), {tag, " empty_n"}, empty_n, lvl() != 0);
    chk(full_n == (lvl() != DEPTH), {tag, " full_n"}, full_n, lvl() != DEPTH);
    chk(half_n == (lvl() <= DEPTH/2), {tag, " half_n"}, half_n, lvl() <= DEPTH/2);
  endtask

  // Driver: applies one cycle of strobes and updates the reference model.
  task automatic step(input bit w, input bit r, input bit t, input int d);
    bit wa, ra;
    wr_n = !w; rd_n = !r; rt_n = !t; wr_data = d[W-1:0];
    if (t) begin
      ridx = 0;
    end else begin
      wa = w && (lvl() < DEPTH);
      ra = r && (lvl() > 0);
      if (ra) begin expq.push_back(hist[ridx]); ridx++; end
      if (wa) begin hist.push_back(d & ((1 << W) - 1)); widx++; end
    end
    @(posedge clk);
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(!empty_n && full_n && half_n && !rd_valid, "R1 in reset",
        {empty_n, full_n, half_n, rd_valid}, 4'b0110);
    rst = 1'b0;
    hist.delete(); expq.delete(); widx = 0; ridx = 0;
    @(negedge clk);
    chk(!empty_n && full_n && half_n && !rd_valid, "R1 after reset",
        {empty_n, full_n, half_n, rd_valid}, 4'b0110);
  endtask

  // Monitor: pops expected words as the design presents them.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && rd_valid) begin
        if (expq.size() == 0) chk(1'b0, "R5 unexpected rd_valid", 1, 0);
        else begin
          int e;
          e = expq.pop_front();
          chk(int'(rd_data) == e, {cur_tag, " rd_data"}, rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R5: read on empty is ignored
    step(0, 1, 0, 0); check_flags("R5");
    step(0, 1, 0, 0); check_flags("R5");

    // R3: single word in and out
    step(1, 0, 0, 9'h1A5); check_flags("R3 one word");
    step(0, 1, 0, 0);      check_flags("R3 drained");

    // R6/R7: fill to full, checking every level
    cur_tag = "R2";
    for (int i = 0; i < DEPTH; i++) begin
      step(1, 0, 0, 16 + i * 3);
      check_flags((i + 1 == DEPTH/2 + 1) ? "R6 threshold" : "R7 fill");
    end
    // R4: writes while full are dropped
    step(1, 0, 0, 9'h0FF); check_flags("R4");
    step(1, 0, 0, 9'h0EE); check_flags("R4");
    // R7: one read releases full
    step(0, 1, 0, 0); check_flags("R7 release");
    // R6: drain down across the half threshold
    for (int i = 0; i < DEPTH - 1; i++) begin
      step(0, 1, 0, 0);
      check_flags((lvl() == DEPTH/2) ? "R6 back to half" : "R6 drain");
    end
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R4 no stray words", expq.size(), 0);

    // R10: simultaneous read and write mid-level
    step(1, 0, 0, 101); step(1, 0, 0, 102); step(1, 0, 0, 103);
    for (int i = 0; i < 5; i++) begin
      step(1, 1, 0, 200 + i); check_flags("R10");
    end
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0);
    check_flags("R10 drained");

    // R11: simultaneous on empty stores, does not read
    step(1, 1, 0, 300); check_flags("R11");
    step(0, 1, 0, 0);   check_flags("R11 drained");
    repeat (2) @(negedge clk);

    // R8/R9: rewind after partial read
    do_reset();
    cur_tag = "R9";
    for (int i = 0; i < 5; i++) step(1, 0, 0, 50 + i);
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0);
    step(1, 1, 1, 77); check_flags("R8 rewind");
    step(1, 0, 0, 60); step(1, 0, 0, 61);
    check_flags("R9");
    for (int i = 0; i < 7; i++) step(0, 1, 0, 0);
    check_flags("R9 replayed");

    // R8: rewind with DEPTH writes since reset restores full
    do_reset();
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 400 + i);
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 0);
    check_flags("R8 empty before");
    step(0, 0, 1, 0); check_flags("R8 full after rewind");
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 0);
    check_flags("R9 full replay");
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R2 all words seen", expq.size(), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule